// File: doc/BRIEF.md
# Wakeup Interrupt Latch and Forward Controller

This block sits between a bank of GPIO-class interrupt lines, a group of direct interrupt lines and a parent interrupt controller. Each GPIO pin has a small configuration word: a trigger type, an enable and a forwarding mask. A mode register sets how GPIO lines reach the parent.

With mode 0 (pass-through), each enabled GPIO line is synchronized and forwarded unchanged. Nothing is latched and the mask has no effect. With any non-zero mode (secondary-controller), a qualifying event on an enabled GPIO pin sets a pending bit. The pending bit is driven to the parent as a level interrupt while the pin is unmasked. It stays set until software clears it with a write-one-to-clear. Direct lines are wired straight through in every mode.

Software reaches the block through a plain single-cycle register strobe port with registered read data. The port is control traffic, so it has no valid/ready handshake and never stalls: a write lands on the clock edge where `reg_wr` is sampled high. Read data appears on the cycle after `reg_rd`. The word address map is: 0x000 mode, 0x001 version (read-only), 0x010 + b status bank b (bit i of bank b is pin 32·b+i), and 0x100 + i the configuration of pin i.

Top module: `irq_wake_gateway`

## Requirements
- R1: After reset, the mode register reads 0 (pass-through), every pin configuration reads 0x10 (masked, disabled, trigger 0), every status bank reads 0 and `gpio_out` is 0.
- R2: Mode register writes store the full data word and read back unchanged. A value of 0 selects pass-through, and any non-zero value selects secondary-controller mode.
- R3: Address 0x001 always reads 0x30200. Writes to it are ignored.
- R4: `direct_out` equals `direct_in` combinationally in both modes. It is never latched.
- R5: In pass-through, `gpio_out[i]` is the two-flop synchronized `gpio_in[i]` ANDed with the pin's enable (bit 3). It rises on the second clock edge after the input changes. The mask (bit 4) has no effect, and no status bit is ever set.
- R6: In secondary-controller mode, with enable set, the trigger field (bits [2:0]) selects when the pin latches. The codes are 0 level high, 1 level low, 2 rising edge, 3 falling edge and 4 both edges. Edges are judged on the synchronized input. Codes 5 to 7 never latch.
- R7: In secondary-controller mode, a pending pin drives `gpio_out[i]` high as a level while its mask bit 4 is 0. While the mask is 1, the pin stays pending in status but is not forwarded.
- R8: A pin whose enable bit 3 is 0 never becomes pending.
- R9: Writing 1 to a pin's bit in its status bank clears the pending bit from the cycle after the write. Writing 0 leaves it alone. A qualifying event in the same cycle wins over the clear.
- R10: Configuration addresses keep only data bits [4:0] and read them back zero-extended. Unmapped addresses read 0. Read data is valid on the cycle after the read strobe.
- R11: Whenever the mode is pass-through, all pending bits are dropped. A later return to secondary-controller mode starts with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_GPIO | Raw GPIO-class interrupt lines |
| direct_in | input | NUM_DIRECT | Direct interrupt lines |
| gpio_out | output | NUM_GPIO | GPIO interrupts toward the parent controller |
| direct_out | output | NUM_DIRECT | Direct interrupts toward the parent controller |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after `reg_rd` |

## Verification
The hardest cases to reach are the collisions. One is a status clear that meets a level trigger still asserted on the same edge. Another is a pin that was enabled on a line already sitting at its active level. The bench reaches both by sweeping every pin, every trigger code and every pair of input levels. For each pair, one level is held across configuration and clearing, and the other level is then applied. The expected pending value is computed from the trigger code and the two levels. A mode drop with a pin pending, and a masked pin that becomes pending and is then unmasked, are each driven in turn.

// File: rtl/irqgw_pkg.sv
package irqgw_pkg;

  typedef enum logic [2:0] {
    TRIG_LVL_HI = 3'd0,
    TRIG_LVL_LO = 3'd1,
    TRIG_RISE   = 3'd2,
    TRIG_FALL   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef struct packed {
    logic       mask;
    logic       en;
    logic [2:0] trig;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);
  localparam pin_cfg_t CFG_RESET = '{mask: 1'b1, en: 1'b0, trig: 3'd0};

  localparam int ADR_MODE = 'h000;
  localparam int ADR_VER  = 'h001;
  localparam int ADR_STAT = 'h010;
  localparam int ADR_CFG  = 'h100;

endpackage

// File: rtl/irqgw_sync.sv
module irqgw_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irqgw_pin.sv
module irqgw_pin
  import irqgw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_sync,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             clr,
  input  logic             sec_mode,
  output pin_cfg_t         cfg_o,
  output logic             hit_o,
  output logic             pend_o,
  output logic             out_o
);
  pin_cfg_t cfg_q;
  logic     prev_q;
  logic     pend_q;
  logic     hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (cfg_wr) cfg_q <= pin_cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= lvl_sync;
  end

  always_comb begin
    hit = 1'b0;
    if (cfg_q.en) begin
      case (cfg_q.trig)
        TRIG_LVL_HI: hit = lvl_sync;
        TRIG_LVL_LO: hit = !lvl_sync;
        TRIG_RISE:   hit = lvl_sync && !prev_q;
        TRIG_FALL:   hit = !lvl_sync && prev_q;
        TRIG_BOTH:   hit = lvl_sync ^ prev_q;
        default:     hit = 1'b0;
      endcase
    end
  end

  // event wins over a clear in the same cycle; leaving secondary mode drops all
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (!sec_mode) pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign out_o  = sec_mode ? (pend_q && !cfg_q.mask) : (lvl_sync && cfg_q.en);
  assign cfg_o  = cfg_q;
  assign hit_o  = hit;
  assign pend_o = pend_q;
endmodule

// File: rtl/irqgw_regs.sv
module irqgw_regs
  import irqgw_pkg::*;
#(
  parameter int NUM_GPIO = 256,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] VERSION = 'h30200
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  pin_cfg_t [NUM_GPIO-1:0]       cfg_vec,
  input  logic [NUM_GPIO-1:0]           pend,
  output logic [NUM_GPIO-1:0]           cfg_wr,
  output logic [CFG_W-1:0]              cfg_wdata,
  output logic [NUM_GPIO-1:0]           clr,
  output logic                          sec_mode
);
  localparam int NUM_BANKS = (NUM_GPIO + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_BANKS * DATA_W;

  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] rd_next;
  logic [PAD_W-1:0]  pend_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (reg_wr && reg_addr == ADDR_W'(ADR_MODE)) mode_q <= reg_wdata;
  end
  assign sec_mode  = |mode_q;
  assign cfg_wdata = reg_wdata[CFG_W-1:0];
  assign pend_pad  = PAD_W'(pend);

  genvar i;
  generate
    for (i = 0; i < NUM_GPIO; i++) begin : g_dec
      assign cfg_wr[i] = reg_wr && (reg_addr == ADDR_W'(ADR_CFG + i));
      assign clr[i]    = reg_wr && (reg_addr == ADDR_W'(ADR_STAT + i / DATA_W))
                         && reg_wdata[i % DATA_W];
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(ADR_MODE)) rd_next = mode_q;
    if (reg_addr == ADDR_W'(ADR_VER))  rd_next = VERSION;
    for (int b = 0; b < NUM_BANKS; b++)
      if (reg_addr == ADDR_W'(ADR_STAT + b)) rd_next = pend_pad[b*DATA_W +: DATA_W];
    for (int p = 0; p < NUM_GPIO; p++)
      if (reg_addr == ADDR_W'(ADR_CFG + p)) rd_next = DATA_W'(cfg_vec[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/irq_wake_gateway.sv
module irq_wake_gateway
  import irqgw_pkg::*;
#(
  parameter int NUM_GPIO   = 256,
  parameter int NUM_DIRECT = 32,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] VERSION = 'h30200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GPIO-1:0]   gpio_in,
  input  logic [NUM_DIRECT-1:0] direct_in,
  output logic [NUM_GPIO-1:0]   gpio_out,
  output logic [NUM_DIRECT-1:0] direct_out,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata
);
  logic [NUM_GPIO-1:0]     gpio_sync;
  pin_cfg_t [NUM_GPIO-1:0] cfg_vec;
  logic [NUM_GPIO-1:0]     cfg_wr_vec;
  logic [CFG_W-1:0]        cfg_wdata;
  logic [NUM_GPIO-1:0]     clr_vec;
  logic [NUM_GPIO-1:0]     pend_vec;
  logic [NUM_GPIO-1:0]     hit_vec;
  logic [NUM_GPIO-1:0]     en_vec;
  logic [NUM_GPIO-1:0]     mask_vec;
  logic                    sec_mode;

  assign direct_out = direct_in;

  irqgw_sync #(.W(NUM_GPIO), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_sync)
  );

  irqgw_regs #(
    .NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_vec(cfg_vec), .pend(pend_vec),
    .cfg_wr(cfg_wr_vec), .cfg_wdata(cfg_wdata), .clr(clr_vec),
    .sec_mode(sec_mode)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_GPIO; i++) begin : g_pin
      irqgw_pin pin_i (
        .clk(clk), .rst_n(rst_n),
        .lvl_sync(gpio_sync[i]),
        .cfg_wr(cfg_wr_vec[i]), .cfg_wdata(cfg_wdata),
        .clr(clr_vec[i]), .sec_mode(sec_mode),
        .cfg_o(cfg_vec[i]), .hit_o(hit_vec[i]),
        .pend_o(pend_vec[i]), .out_o(gpio_out[i])
      );
      assign en_vec[i]   = cfg_vec[i].en;
      assign mask_vec[i] = cfg_vec[i].mask;
    end
  endgenerate
endmodule

// File: rtl/irqgw_checker.sv
module irqgw_checker #(
  parameter int NUM_GPIO = 256,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter logic [DATA_W-1:0] VERSION = 'h30200
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic                sec_mode,
  input logic [NUM_GPIO-1:0] pend,
  input logic [NUM_GPIO-1:0] hit,
  input logic [NUM_GPIO-1:0] clr,
  input logic [NUM_GPIO-1:0] en_vec,
  input logic [NUM_GPIO-1:0] mask_vec,
  input logic [NUM_GPIO-1:0] gpio_out
);
  a_r3_version_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(1)) |=> (reg_rdata == VERSION));

  a_r11_pass_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_mode |=> (pend == '0));

  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mode |-> ((gpio_out & mask_vec) == '0));

  genvar i;
  generate
    for (i = 0; i < NUM_GPIO; i++) begin : g_chk
      a_r8_disabled_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[i] && !en_vec[i]) |=> !pend[i]);
      a_r9_clear_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !hit[i]) |=> !pend[i]);
      a_r6_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_mode && hit[i]) |=> pend[i]);
    end
  endgenerate
endmodule

bind irq_wake_gateway irqgw_checker #(
  .NUM_GPIO(NUM_GPIO), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .sec_mode(sec_mode), .pend(pend_vec),
  .hit(hit_vec), .clr(clr_vec), .en_vec(en_vec), .mask_vec(mask_vec),
  .gpio_out(gpio_out)
);

// File: tb/irq_wake_gateway_tb_top.sv
module irq_wake_gateway_tb_top;
  localparam int NG = 8;
  localparam int ND = 4;
  localparam int AW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG-1:0] gpio_in = '0;
  logic [ND-1:0] direct_in = '0;
  logic [NG-1:0] gpio_out;
  logic [ND-1:0] direct_out;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] rd;

  irq_wake_gateway #(.NUM_GPIO(NG), .NUM_DIRECT(ND), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .direct_in(direct_in),
    .gpio_out(gpio_out), .direct_out(direct_out),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [DW-1:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(int addr, output logic [DW-1:0] data);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
    data = reg_rdata;
  endtask

  function automatic logic exp_latch(int t, logic v0, logic v1);
    case (t)
      0: return v0 | v1;
      1: return !v0 | !v1;
      2: return !v0 & v1;
      3: return v0 & !v1;
      4: return v0 ^ v1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state
    rdreg('h000, rd); chk("R1 mode after reset", rd, 0);
    for (int p = 0; p < NG; p++) begin
      rdreg('h100 + p, rd); chk("R1 cfg after reset", rd, 'h10);
    end
    rdreg('h010, rd); chk("R1 status after reset", rd, 0);
    chk("R1 gpio_out after reset", DW'(gpio_out), 0);

    // R3 version read-only
    rdreg('h001, rd); chk("R3 version", rd, 'h30200);
    wr('h001, 'h12345678);
    rdreg('h001, rd); chk("R3 version after write", rd, 'h30200);

    // R10 config keeps 5 bits, unmapped reads 0
    wr('h105, 'hFFFF_FFFF);
    rdreg('h105, rd); chk("R10 cfg bits kept", rd, 'h1F);
    wr('h105, 'h10);
    rdreg('h3FF, rd); chk("R10 unmapped read", rd, 0);
    rdreg('h011, rd); chk("R10 unmapped bank read", rd, 0);

    // R4 direct lines, pass-through mode
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); direct_in = ND'(v); #1;
      chk("R4 direct pass mode", DW'(direct_out), DW'(v));
    end

    // R5 pass-through: latency, mask ignored, enable gates, no status
    wr('h103, 'h18);
    wr('h104, 'h10);
    @(negedge clk); gpio_in = 8'h18;
    @(negedge clk); chk("R5 pass after one edge", DW'(gpio_out), 0);
    @(negedge clk); chk("R5 pass after two edges", DW'(gpio_out), 'h08);
    rdreg('h010, rd); chk("R5 no status in pass", rd, 0);
    @(negedge clk); gpio_in = '0;
    wait_n(3);
    chk("R5 pass follows low", DW'(gpio_out), 0);
    wr('h103, 'h10);

    // R2 mode register
    wr('h000, 'h5);
    rdreg('h000, rd); chk("R2 mode readback", rd, 'h5);

    // R4 direct lines, secondary mode
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); direct_in = ND'(15 - v); #1;
      chk("R4 direct secondary mode", DW'(direct_out), DW'(15 - v));
    end

    // R6 sweep: pin x trigger x held level x applied level
    for (int p = 0; p < NG; p++) begin
      for (int t = 0; t < 8; t++) begin
        for (int v0 = 0; v0 < 2; v0++) begin
          for (int v1 = 0; v1 < 2; v1++) begin
            logic e;
            e = exp_latch(t, v0[0], v1[0]);
            @(negedge clk); gpio_in = '0; gpio_in[p] = v0[0];
            wait_n(4);
            wr('h100 + p, DW'('h08 | t));
            wait_n(3);
            wr('h010, 'hFF);
            @(negedge clk); gpio_in[p] = v1[0];
            wait_n(4);
            rdreg('h010, rd);
            chk("R6 status latch", rd, DW'(e) << p);
            chk("R7 level forwarded", DW'(gpio_out), DW'(e) << p);
            wr('h100 + p, 'h10);
            @(negedge clk); gpio_in = '0;
            wait_n(4);
            wr('h010, 'hFF);
          end
        end
      end
    end
    rdreg('h010, rd); chk("R6 status clean after sweep", rd, 0);

    // R7 mask holds but blocks
    wr('h102, 'h1A);
    @(negedge clk); gpio_in[2] = 1'b1;
    wait_n(4);
    @(negedge clk); gpio_in[2] = 1'b0;
    wait_n(4);
    rdreg('h010, rd); chk("R7 masked still pending", rd, 'h04);
    chk("R7 masked not forwarded", DW'(gpio_out), 0);
    wr('h102, 'h0A);
    chk("R7 unmask forwards", DW'(gpio_out), 'h04);

    // R9 clear of other bit, then clear timing
    wr('h010, 'h01);
    chk("R9 other bit clear leaves pending", DW'(gpio_out), 'h04);
    wr('h010, 'h04);
    chk("R9 cleared cycle after write", DW'(gpio_out), 0);
    rdreg('h010, rd); chk("R9 status cleared", rd, 0);

    // R9 level held: event wins over clear
    wr('h106, 'h08);
    @(negedge clk); gpio_in[6] = 1'b1;
    wait_n(4);
    wr('h010, 'h40);
    chk("R9 held level relatches", DW'(gpio_out), 'h40);
    wr('h106, 'h10);
    @(negedge clk); gpio_in[6] = 1'b0;
    wait_n(4);
    wr('h010, 'h40);

    // R8 disabled pin never latches
    wr('h101, 'h02);
    @(negedge clk); gpio_in[1] = 1'b1;
    wait_n(4);
    @(negedge clk); gpio_in[1] = 1'b0;
    wait_n(4);
    rdreg('h010, rd); chk("R8 disabled no latch", rd, 0);
    chk("R8 disabled no output", DW'(gpio_out), 0);

    // R11 leaving secondary drops pending
    wr('h101, 'h0A);
    @(negedge clk); gpio_in[1] = 1'b1;
    wait_n(4);
    @(negedge clk); gpio_in[1] = 1'b0;
    wait_n(4);
    rdreg('h010, rd); chk("R11 pending before mode drop", rd, 'h02);
    wr('h000, 'h0);
    wr('h000, 'h1);
    rdreg('h010, rd); chk("R11 nothing pending after return", rd, 0);
    chk("R11 no output after return", DW'(gpio_out), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule